// File: doc/BRIEF.md
# Indirect Register Access Port

This block gives a host a narrow window onto a larger bank of internal registers. The host sees four 32-bit words at word offsets 0 to 3. Offset 2 (byte offset 8) holds a pointer register. It carries a byte address into the internal space and an auto-advance flag. Offset 3 (byte offset 12) is the data window. Each read or write of the window goes to the internal entry that the pointer selects. Offsets 0 and 1 are placeholders for neighbouring control words and are not implemented here.

Internal entries are 68 bits wide. The internal space is byte addressed in steps of 4, so the two low pointer bits are free. They act as a slice selector: `00` selects entry bits 31:0, `01` selects bits 63:32, and `10` or `11` selects the top four bits 67:64, which appear in window bits 3:0. When the flag at pointer bit 15 is set, each window access adds 4 to the pointer after it completes. This lets software walk adjacent entries without rewriting the pointer. The register file side is a simple synchronous port. The block drives a full-width write with a bit mask, or a read strobe, and the read data is expected one cycle after the strobe.

A small controller sequences each access through five states. IDLE accepts a request. WRITE drives the register-file write. READ issues the register-file read. CAPTURE latches the returned slice. DONE raises the acknowledge. The transitions are: IDLE→DONE for pointer and placeholder accesses, IDLE→WRITE→DONE for window writes, IDLE→READ→CAPTURE→DONE for window reads, and DONE→IDLE always.

Top module: `indirect_reg_port`

## Requirements
- R1: After reset the pointer reads 0 (flag clear, address 0), `host_ack`, `rf_wr` and `rf_rd` are low.
- R2: A write to offset 2 updates pointer bits 7:0 when `host_be[0]` is set and bits 15:8 when `host_be[1]` is set; `host_be[3:2]` have no effect; a read of offset 2 returns the flag in bit 15, the address in bits ADDR_W-1:0 and zeros elsewhere.
- R3: With slice `00`, a window write updates entry bits 31:0 only, byte lane n written only when `host_be[n]` is set.
- R4: With slice `01`, a window write updates entry bits 63:32 only, under the same per-lane enables.
- R5: With slice `1x`, a window write places window bits 3:0 into entry bits 67:64 when `host_be[0]` is set (other lanes irrelevant), and a window read returns those bits in 3:0 with bits 31:4 zero.
- R6: A window read returns the 32-bit slice chosen by the pointer's low two bits.
- R7: With the flag set, every window read or write adds 4 to the pointer afterwards and keeps the slice bits; with the flag clear the pointer is unchanged.
- R8: The pointer address wraps modulo 2^ADDR_W when advancing.
- R9: Each request gets exactly one single-cycle acknowledge: 1 cycle after the request for offsets 0–2, 2 cycles for a window write, 3 for a window read; requests arriving while an access is in flight are ignored.
- R10: Offsets 0 and 1 read as zero and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Request strobe, sampled in IDLE |
| host_we | input | 1 | 1 = write, 0 = read |
| host_off | input | 2 | Word offset (0..3) |
| host_be | input | 4 | Byte enables for writes |
| host_wdata | input | 32 | Write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with `host_ack` |
| rf_idx | output | ADDR_W-2 | Internal entry index |
| rf_wr | output | 1 | Register-file write strobe |
| rf_rd | output | 1 | Register-file read strobe |
| rf_wdata | output | ENTRY_W | Write data placed at the selected slice |
| rf_wmask | output | ENTRY_W | Bit write mask |
| rf_rdata | input | ENTRY_W | Read data, valid the cycle after `rf_rd` |

## Verification
A pointer that advances wrongly shows up on the very next pointer readback, because the post-increment value is visible at offset 2 within one access. It also shows up as a read of the neighbouring entry on the following window access. A wrong slice decode shows up as a register-file mask that touches lanes outside the selected slice during the write cycle itself. After the write it shows up as a corrupted neighbour slice when that slice is read back. Controller state faults show up at the ports as an acknowledge that comes at the wrong latency, as a doubled acknowledge, or as a second request that is accepted when it should have been dropped.

// File: rtl/irp_pkg.sv
package irp_pkg;

    localparam int HOST_W   = 32;
    localparam int FLAG_BIT = 15;

    localparam logic [1:0] OFF_CMD  = 2'd0;
    localparam logic [1:0] OFF_PARM = 2'd1;
    localparam logic [1:0] OFF_PTR  = 2'd2;
    localparam logic [1:0] OFF_WIN  = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WRITE   = 3'd1,
        ST_READ    = 3'd2,
        ST_CAPTURE = 3'd3,
        ST_DONE    = 3'd4
    } irp_state_e;

endpackage

// File: rtl/irp_ptr_reg.sv
module irp_ptr_reg #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_be,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_flag,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              auto_inc,
    output logic [15:0]       view
);
    localparam int IDX_W = ADDR_W - 2;

    logic [ADDR_W-1:0] addr_q;
    logic              flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            flag_q <= 1'b0;
        end else if (wr_en) begin
            for (int i = 0; i < ADDR_W; i++) begin
                if (wr_be[i / 8]) addr_q[i] <= wr_addr[i];
            end
            if (wr_be[1]) flag_q <= wr_flag;
        end else if (step && flag_q) begin
            addr_q <= {addr_q[ADDR_W-1:2] + IDX_W'(1), addr_q[1:0]};
        end
    end

    always_comb begin
        view                   = '0;
        view[ADDR_W-1:0]       = addr_q;
        view[irp_pkg::FLAG_BIT] = flag_q;
    end

    assign cur_addr = addr_q;
    assign auto_inc = flag_q;

endmodule

// File: rtl/irp_slice_map.sv
module irp_slice_map #(
    parameter int ENTRY_W = 68
) (
    input  logic [1:0]         slice,
    input  logic [3:0]         be,
    input  logic [31:0]        wdata,
    input  logic [ENTRY_W-1:0] rdata,
    output logic [ENTRY_W-1:0] ent_wdata,
    output logic [ENTRY_W-1:0] ent_wmask,
    output logic [31:0]        rd_word
);
    localparam int TOP_W = ENTRY_W - 64;

    logic [31:0] lane_bits;

    for (genvar b = 0; b < 4; b++) begin : g_lane
        assign lane_bits[8*b +: 8] = {8{be[b]}};
    end

    always_comb begin
        ent_wdata = '0;
        ent_wmask = '0;
        rd_word   = '0;
        unique case (slice)
            2'b00: begin
                ent_wdata[31:0] = wdata;
                ent_wmask[31:0] = lane_bits;
                rd_word         = rdata[31:0];
            end
            2'b01: begin
                ent_wdata[63:32] = wdata;
                ent_wmask[63:32] = lane_bits;
                rd_word          = rdata[63:32];
            end
            2'b10, 2'b11: begin
                ent_wdata[ENTRY_W-1:64] = wdata[TOP_W-1:0];
                ent_wmask[ENTRY_W-1:64] = lane_bits[TOP_W-1:0];
                rd_word[TOP_W-1:0]      = rdata[ENTRY_W-1:64];
            end
        endcase
    end

endmodule

// File: rtl/irp_ctrl.sv
module irp_ctrl
    import irp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_req,
    input  logic       host_we,
    input  logic [1:0] host_off,
    output logic       take,
    output logic       ptr_wr,
    output logic       cap_reg,
    output logic       rf_wr,
    output logic       rf_rd,
    output logic       cap_win,
    output logic       step,
    output logic       ack
);
    irp_state_e state_q, state_d;

    logic accept;
    assign accept = (state_q == ST_IDLE) && host_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (host_req) begin
                    if (host_off == OFF_WIN) state_d = host_we ? ST_WRITE : ST_READ;
                    else                     state_d = ST_DONE;
                end
            end
            ST_WRITE:   state_d = ST_DONE;
            ST_READ:    state_d = ST_CAPTURE;
            ST_CAPTURE: state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        take    = accept;
        ptr_wr  = accept && host_we && (host_off == OFF_PTR);
        cap_reg = accept && !host_we && (host_off != OFF_WIN);
        rf_wr   = (state_q == ST_WRITE);
        rf_rd   = (state_q == ST_READ);
        cap_win = (state_q == ST_CAPTURE);
        step    = (state_q == ST_WRITE) || (state_q == ST_CAPTURE);
        ack     = (state_q == ST_DONE);
    end

endmodule

// File: rtl/indirect_reg_port.sv
module indirect_reg_port
    import irp_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int ENTRY_W = 68,
    localparam int IDX_W  = ADDR_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [1:0]         host_off,
    input  logic [3:0]         host_be,
    input  logic [31:0]        host_wdata,
    output logic               host_ack,
    output logic [31:0]        host_rdata,
    output logic [IDX_W-1:0]   rf_idx,
    output logic               rf_wr,
    output logic               rf_rd,
    output logic [ENTRY_W-1:0] rf_wdata,
    output logic [ENTRY_W-1:0] rf_wmask,
    input  logic [ENTRY_W-1:0] rf_rdata
);
    logic              take, ptr_wr, cap_reg, cap_win, step;
    logic [ADDR_W-1:0] cur_addr;
    logic              auto_inc;
    logic [15:0]       ptr_view;
    logic [3:0]        be_q;
    logic [31:0]       wd_q;
    logic [31:0]       rdata_q;
    logic [31:0]       win_word;

    irp_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_req (host_req),
        .host_we  (host_we),
        .host_off (host_off),
        .take     (take),
        .ptr_wr   (ptr_wr),
        .cap_reg  (cap_reg),
        .rf_wr    (rf_wr),
        .rf_rd    (rf_rd),
        .cap_win  (cap_win),
        .step     (step),
        .ack      (host_ack)
    );

    irp_ptr_reg #(.ADDR_W(ADDR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ptr_wr),
        .wr_be    (host_be[1:0]),
        .wr_addr  (host_wdata[ADDR_W-1:0]),
        .wr_flag  (host_wdata[FLAG_BIT]),
        .step     (step),
        .cur_addr (cur_addr),
        .auto_inc (auto_inc),
        .view     (ptr_view)
    );

    irp_slice_map #(.ENTRY_W(ENTRY_W)) u_map (
        .slice     (cur_addr[1:0]),
        .be        (be_q),
        .wdata     (wd_q),
        .rdata     (rf_rdata),
        .ent_wdata (rf_wdata),
        .ent_wmask (rf_wmask),
        .rd_word   (win_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            be_q    <= '0;
            wd_q    <= '0;
            rdata_q <= '0;
        end else begin
            if (take) begin
                be_q <= host_be;
                wd_q <= host_wdata;
            end
            if (cap_reg) rdata_q <= (host_off == OFF_PTR) ? {16'h0, ptr_view} : 32'h0;
            else if (cap_win) rdata_q <= win_word;
        end
    end

    assign rf_idx     = cur_addr[ADDR_W-1:2];
    assign host_rdata = rdata_q;

endmodule

// File: rtl/irp_checker.sv
module irp_checker #(
    parameter int ADDR_W  = 8,
    parameter int ENTRY_W = 68
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_ack,
    input logic               rf_wr,
    input logic               rf_rd,
    input logic [ENTRY_W-1:0] rf_wmask,
    input logic [ADDR_W-1:0]  cur_addr,
    input logic               auto_inc
);
    // R9: acknowledge is a single-cycle pulse
    assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    // R9: a register-file write completes on the next cycle
    assert_write_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr |=> host_ack);

    // R9: a register-file read completes two cycles later
    assert_read_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd |=> !host_ack ##1 host_ack);

    // R3: low slice writes touch only bits 31:0
    assert_mask_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr && cur_addr[1:0] == 2'b00) |-> rf_wmask[ENTRY_W-1:32] == '0);

    // R4: middle slice writes touch only bits 63:32
    assert_mask_mid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr && cur_addr[1:0] == 2'b01) |-> (rf_wmask[31:0] == '0 && rf_wmask[ENTRY_W-1:64] == '0));

    // R5: top slice writes touch only bits above 63
    assert_mask_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr && cur_addr[1]) |-> rf_wmask[63:0] == '0);

    // R7/R8: with the flag set the index advances by one entry, wrapping, slice kept
    assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr && auto_inc) |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]) + 1'b1
                                 && cur_addr[1:0] == $past(cur_addr[1:0])));

    // R7: with the flag clear the pointer holds across a window write
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr && !auto_inc) |=> $stable(cur_addr));

endmodule

bind indirect_reg_port irp_checker #(.ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_ack (host_ack),
    .rf_wr    (rf_wr),
    .rf_rd    (rf_rd),
    .rf_wmask (rf_wmask),
    .cur_addr (cur_addr),
    .auto_inc (auto_inc)
);

// File: tb/indirect_reg_port_test.sv
module indirect_reg_port_test;

    localparam int ADDR_W  = 8;
    localparam int ENTRY_W = 68;
    localparam int IDX_W   = ADDR_W - 2;
    localparam int DEPTH   = 1 << IDX_W;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               host_req = 1'b0;
    logic               host_we = 1'b0;
    logic [1:0]         host_off = '0;
    logic [3:0]         host_be = '0;
    logic [31:0]        host_wdata = '0;
    logic               host_ack;
    logic [31:0]        host_rdata;
    logic [IDX_W-1:0]   rf_idx;
    logic               rf_wr, rf_rd;
    logic [ENTRY_W-1:0] rf_wdata, rf_wmask;
    logic [ENTRY_W-1:0] rf_rdata;

    logic [ENTRY_W-1:0] mem [DEPTH];

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10ns clk = ~clk;

    indirect_reg_port #(.ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)) uut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_off(host_off), .host_be(host_be), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_rdata(host_rdata), .rf_idx(rf_idx),
        .rf_wr(rf_wr), .rf_rd(rf_rd), .rf_wdata(rf_wdata), .rf_wmask(rf_wmask),
        .rf_rdata(rf_rdata)
    );

    // environment register file: masked write, one-cycle read latency
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rf_rdata <= '0;
        end else begin
            if (rf_wr) mem[rf_idx] <= (mem[rf_idx] & ~rf_wmask) | (rf_wdata & rf_wmask);
            if (rf_rd) rf_rdata <= mem[rf_idx];
        end
    end

    typedef struct packed {
        logic [1:0]  off;
        logic        we;
        logic [3:0]  be;
        logic [31:0] wd;
        logic        chk;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 41;
    localparam vec_t VECS [NV] = '{
        '{2'd2, 1'b1, 4'h3, 32'h0000_0010, 1'b0, 32'h0,          4'd2},  // R2 idx4 slice0
        '{2'd2, 1'b0, 4'h0, 32'h0,         1'b1, 32'h0000_0010, 4'd2},  // R2 readback
        '{2'd3, 1'b1, 4'hF, 32'hDEAD_BEEF, 1'b0, 32'h0,          4'd3},  // R3 low slice
        '{2'd2, 1'b1, 4'h3, 32'h0000_0011, 1'b0, 32'h0,          4'd4},
        '{2'd3, 1'b1, 4'hF, 32'h1234_5678, 1'b0, 32'h0,          4'd4},  // R4 mid slice
        '{2'd2, 1'b1, 4'h3, 32'h0000_0012, 1'b0, 32'h0,          4'd5},
        '{2'd3, 1'b1, 4'hF, 32'hFFFF_FFFA, 1'b0, 32'h0,          4'd5},  // R5 top nibble
        '{2'd3, 1'b0, 4'h0, 32'h0,         1'b1, 32'h0000_000A, 4'd5},  // R5 upper zeros
        '{2'd2, 1'b1, 4'h3, 32'h0000_0010, 1'b0, 32'h0,          4'd6},
        '{2'd3, 1'b0, 4'h0, 32'h0,         1'b1, 32'hDEAD_BEEF, 4'd6},  // R6
        '{2'd2, 1'b1, 4'h3, 32'h0000_0011, 1'b0, 32'h0,          4'd4},
        '{2'd3, 1'b1, 4'h5, 32'hAAAA_BBBB, 1'b0, 32'h0,          4'd4},  // R4 lanes 0,2
        '{2'd3, 1'b0, 4'h0, 32'h0,         1'b1, 32'h12AA_56BB, 4'd4},
        '{2'd2, 1'b1, 4'h7, 32'h00FF_0010, 1'b0, 32'h0,          4'd2},  // R2 lane 2 ignored
        '{2'd2, 1'b0, 4'h0, 32'h0,         1'b1, 32'h0000_0010, 4'd2},
        '{2'd1, 1'b1, 4'hF, 32'hFFFF_FFFF, 1'b0, 32'h0,          4'd10}, // R10
        '{2'd0, 1'b0, 4'h0, 32'h0,         1'b1, 32'h0,          4'd10},
        '{2'd1, 1'b0, 4'h0, 32'h0,         1'b1, 32'h0,          4'd10},
        '{2'd2, 1'b0, 4'h0, 32'h0,         1'b1, 32'h0000_0010, 4'd10},
        '{2'd2, 1'b1, 4'h3, 32'h0000_8020, 1'b0, 32'h0,          4'd7},  // R7 flag on
        '{2'd3, 1'b1, 4'hF, 32'h1111_1111, 1'b0, 32'h0,          4'd7},
        '{2'd3, 1'b1, 4'hF, 32'h2222_2222, 1'b0, 32'h0,          4'd7},
        '{2'd2, 1'b0, 4'h0, 32'h0,         1'b1, 32'h0000_8028, 4'd7},
        '{2'd2, 1'b1, 4'h3, 32'h0000_8020, 1'b0, 32'h0,          4'd7},
        '{2'd3, 1'b0, 4'h0, 32'h0,         1'b1, 32'h1111_1111, 4'd7},
        '{2'd3, 1'b0, 4'h0, 32'h0,         1'b1, 32'h2222_2222, 4'd7},
        '{2'd2, 1'b0, 4'h0, 32'h0,         1'b1, 32'h0000_8028, 4'd7},
        '{2'd2, 1'b1, 4'h3, 32'h0000_8011, 1'b0, 32'h0,          4'd7},
        '{2'd3, 1'b0, 4'h0, 32'h0,         1'b1, 32'h12AA_56BB, 4'd7},
        '{2'd2, 1'b0, 4'h0, 32'h0,         1'b1, 32'h0000_8015, 4'd7},  // R7 slice kept
        '{2'd2, 1'b1, 4'h3, 32'h0000_80FC, 1'b0, 32'h0,          4'd8},
        '{2'd3, 1'b1, 4'hF, 32'h0BAD_F00D, 1'b0, 32'h0,          4'd8},
        '{2'd2, 1'b0, 4'h0, 32'h0,         1'b1, 32'h0000_8000, 4'd8},  // R8 wrap
        '{2'd2, 1'b1, 4'h3, 32'h0000_00FC, 1'b0, 32'h0,          4'd8},
        '{2'd3, 1'b0, 4'h0, 32'h0,         1'b1, 32'h0BAD_F00D, 4'd8},
        '{2'd2, 1'b0, 4'h0, 32'h0,         1'b1, 32'h0000_00FC, 4'd7},  // R7 flag off
        '{2'd2, 1'b1, 4'h1, 32'h0000_8044, 1'b0, 32'h0,          4'd2},  // R2 lane 1 off
        '{2'd2, 1'b0, 4'h0, 32'h0,         1'b1, 32'h0000_0044, 4'd2},
        '{2'd2, 1'b1, 4'h3, 32'h0000_0012, 1'b0, 32'h0,          4'd5},
        '{2'd3, 1'b1, 4'hE, 32'hFFFF_FFF5, 1'b0, 32'h0,          4'd5},  // R5 lane 0 off
        '{2'd3, 1'b0, 4'h0, 32'h0,         1'b1, 32'h0000_000A, 4'd5}
    };

    task automatic check(input string req, input logic [ENTRY_W-1:0] act, input logic [ENTRY_W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic [1:0] off, input logic we, input logic [3:0] be,
                          input logic [31:0] wd, output logic [31:0] rd, output int lat);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_off = off; host_be = be; host_wdata = wd;
        lat = 0;
        do begin
            @(negedge clk);
            host_req = 1'b0;
            lat++;
        end while (!host_ack && lat < 20);
        rd = host_rdata;
    endtask

    function automatic int exp_lat(input logic [1:0] off, input logic we);
        if (off != 2'd3) return 1;
        return we ? 2 : 3;
    endfunction

    initial begin
        #(20ns * 150000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int lat;

        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check("R1 ack", {67'b0, host_ack}, '0);
        check("R1 strobes", {66'b0, rf_wr, rf_rd}, '0);
        rst_n = 1'b1;
        access(2'd2, 1'b0, 4'h0, 32'h0, rd, lat);
        check("R1 pointer", {36'b0, rd}, '0);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].off, VECS[i].we, VECS[i].be, VECS[i].wd, rd, lat);
            check($sformatf("R9 latency row %0d", i), ENTRY_W'(lat), ENTRY_W'(exp_lat(VECS[i].off, VECS[i].we)));
            if (VECS[i].chk)
                check($sformatf("R%0d row %0d", VECS[i].req, i), {36'b0, rd}, {36'b0, VECS[i].exp});
        end

        // R3 R4 R5: neighbouring slices untouched, whole entries as expected
        check("R3 R4 R5 entry4", mem[4], {4'hA, 32'h12AA_56BB, 32'hDEAD_BEEF});
        check("R7 entry8", mem[8], {36'h0, 32'h1111_1111});
        check("R8 entry63", mem[63], {36'h0, 32'h0BAD_F00D});

        // R9: a request while a window read is in flight is dropped
        access(2'd2, 1'b1, 4'h3, 32'h0000_0010, rd, lat);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_off = 2'd3; host_be = 4'h0;
        @(negedge clk);
        host_we = 1'b1; host_off = 2'd2; host_be = 4'h3; host_wdata = 32'h0000_8030;
        @(negedge clk);
        host_req = 1'b0;
        @(negedge clk);
        check("R9 ack after busy", {67'b0, host_ack}, {67'b0, 1'b1});
        check("R9 read data", {36'b0, host_rdata}, {36'b0, 32'hDEAD_BEEF});
        @(negedge clk);
        check("R9 single pulse", {67'b0, host_ack}, '0);
        access(2'd2, 1'b0, 4'h0, 32'h0, rd, lat);
        check("R9 dropped write", {36'b0, rd}, {36'b0, 32'h0000_0010});

        // R1: reset mid-run clears the pointer
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        access(2'd2, 1'b0, 4'h0, 32'h0, rd, lat);
        check("R1 pointer after reset", {36'b0, rd}, '0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule